// File: doc/BRIEF.md
# External Reset Pulse Generator

This block turns a one-cycle watchdog-expiry trigger into a timed external reset or alert pulse. The pulse length is counted in ticks of a 1 MHz timebase that arrives as a one-cycle strobe on `tick_1us`. The block has one 32-bit configuration word. Its low field sets the pulse length. Two hidden state bits choose the asserted polarity and the pad drive style, either driven both ways or open-drain.

The two mode bits change only when a key byte is written into bits 31:24 of the word. Any other top byte leaves them alone, while the low field is still taken from the written data. On readback the mode bits appear as ordinary bits 31 and 30. The pad is modelled by a data value and an output enable, so an open-drain pad can be released when it is idle.

Top module: `rstpulse_gen`

## Requirements
- R1: After reset the readback is 0x000000FF: the length field is 255, both mode bits are 0 (active low, open-drain), pad_oe is 0 and pad_o is 0. A trigger then gives a pulse of 256 ticks.
- R2: Every write stores cfg_wdata[WIDTH_BITS-1:0] into the length field, whatever the top byte. Readback bits 29 down to WIDTH_BITS are 0. The default WIDTH_BITS is 20.
- R3: Writing 0xA5 in bits 31:24 sets the polarity bit (active high). Writing 0x5A there clears it (active low).
- R4: Writing 0xA8 in bits 31:24 sets the drive bit (push-pull). Writing 0x8A there clears it (open-drain).
- R5: A write whose top byte is none of the four keys leaves both mode bits unchanged.
- R6: cfg_rdata bit 31 shows the polarity bit and bit 30 shows the drive bit. A write shows in cfg_rdata from the cycle after it is applied.
- R7: A trigger makes the pulse asserted from the next cycle. With a length value of N, exactly N+1 tick strobes are seen while it is asserted, and the (N+1)th strobe ends it. If a trigger and a tick arrive in the same cycle, the tick is ignored.
- R8: A trigger that arrives during a pulse reloads the count, so N+1 more ticks follow that trigger.
- R9: In push-pull mode pad_oe is 1. pad_o equals the polarity bit while the pulse is asserted and its inverse while idle.
- R10: In open-drain mode pad_o always equals the polarity bit. pad_oe is 1 only while the pulse is asserted.
- R11: A length write during a pulse does not change that pulse. It applies from the next trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1us | input | 1 | One-cycle strobe of the 1 MHz timebase |
| trig | input | 1 | One-cycle watchdog-expiry trigger |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| pad_o | output | 1 | Pad data value |
| pad_oe | output | 1 | Pad output enable |

## Verification
The register part is tried with a sequence of writes that walks through all four keys, with near-miss and zero top bytes, and with length values that set bits above the field. These writes tell key decode apart from plain field storage. The pulse part is tried with lengths 0, 2, 5 and the reset default of 255. This separates an N+1 count from an N or N+2 count. A retrigger in the middle of a pulse and a length rewrite in the middle of a pulse separate a reload from a continued count. The pad levels are checked both idle and asserted in all four polarity and drive combinations. This tells the push-pull rules apart from the open-drain rules.

// File: rtl/rstpulse_gen.sv
module rstpulse_gen #(
  parameter int WIDTH_BITS  = 20,
  parameter int RESET_WIDTH = 255,
  parameter logic [7:0] KEY_POL_HI = 8'hA5,
  parameter logic [7:0] KEY_POL_LO = 8'h5A,
  parameter logic [7:0] KEY_DRV_PP = 8'hA8,
  parameter logic [7:0] KEY_DRV_OD = 8'h8A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_1us,
  input  logic        trig,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        pad_o,
  output logic        pad_oe
);
  localparam int PAD_BITS = 30 - WIDTH_BITS;
  localparam logic [WIDTH_BITS-1:0] RST_LEN = WIDTH_BITS'(RESET_WIDTH);

  logic [WIDTH_BITS-1:0] len_q, cnt_q;
  logic pol_q, drv_q, busy_q;
  logic [7:0] key;
  logic unused_wdata;

  assign key = cfg_wdata[31:24];
  assign unused_wdata = &{1'b0, cfg_wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= RST_LEN;
      pol_q <= 1'b0;
      drv_q <= 1'b0;
    end else if (cfg_we) begin
      len_q <= cfg_wdata[WIDTH_BITS-1:0];
      if (key == KEY_POL_HI) pol_q <= 1'b1;
      else if (key == KEY_POL_LO) pol_q <= 1'b0;
      if (key == KEY_DRV_PP) drv_q <= 1'b1;
      else if (key == KEY_DRV_OD) drv_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (trig) begin
      busy_q <= 1'b1;
      cnt_q  <= len_q;
    end else if (busy_q && tick_1us) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cfg_rdata = {pol_q, drv_q, {PAD_BITS{1'b0}}, len_q};
  assign pad_o  = drv_q ? (busy_q ? pol_q : ~pol_q) : pol_q;
  assign pad_oe = drv_q | busy_q;
endmodule

// File: rtl/rstpulse_gen_chk.sv
module rstpulse_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        trig,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata,
  input logic        pad_o,
  input logic        pad_oe
);
  logic [7:0] top;
  logic other_key;
  assign top = cfg_wdata[31:24];
  assign other_key = (top != 8'hA5) && (top != 8'h5A) && (top != 8'hA8) && (top != 8'h8A);

  AST_TRIG_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (pad_oe && pad_o == cfg_rdata[31])); // R7
  AST_KEY_POL_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && top == 8'hA5) |=> cfg_rdata[31]); // R3
  AST_KEY_POL_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && top == 8'h5A) |=> !cfg_rdata[31]); // R3
  AST_KEY_DRV_OD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && top == 8'h8A) |=> !cfg_rdata[30]); // R4
  AST_OTHER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && other_key) |=> cfg_rdata[31:30] == $past(cfg_rdata[31:30])); // R5
  AST_PP_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[30] |-> pad_oe); // R9
  AST_OD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[30] |-> pad_o == cfg_rdata[31]); // R10
endmodule

bind rstpulse_gen rstpulse_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .cfg_we(cfg_we),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pad_o(pad_o), .pad_oe(pad_oe)
);

// File: tb/test_rstpulse_gen.sv
module test_rstpulse_gen;
  logic clk = 0, rst_n = 0, tick_1us = 0, trig = 0, cfg_we = 0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic pad_o, pad_oe;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rstpulse_gen i_rstpulse_gen (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .trig(trig),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pad_o(pad_o), .pad_oe(pad_oe)
  );

  // {write data, expected readback}; each entry exercises R2, R6 and the key noted
  localparam logic [63:0] VEC [10] = '{
    {32'h00000010, 32'h00000010},  // R5 zero top byte
    {32'hA5000020, 32'h80000020},  // R3 set polarity
    {32'hA8000030, 32'hC0000030},  // R4 set drive
    {32'h12ABCDEF, 32'hC00BCDEF},  // R5, R2 bits above field dropped
    {32'h5A000001, 32'h40000001},  // R3 clear polarity
    {32'h8A000002, 32'h00000002},  // R4 clear drive
    {32'hA7FFFFFF, 32'h000FFFFF},  // R5 near-miss key
    {32'hA8000000, 32'h40000000},  // R4
    {32'h8AFFFFFF, 32'h000FFFFF},  // R4 clear, field all ones
    {32'h5A000000, 32'h00000000}   // R3 clear when already clear
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_wdata = d;
    @(negedge clk); cfg_we = 0; cfg_wdata = '0;
  endtask

  function automatic bit asserted(logic pol);
    return pad_oe && (pad_o == pol);
  endfunction

  task automatic pad_chk(string req, bit busy, logic pol, logic drv);
    logic exp_o, exp_oe;
    exp_o  = drv ? (busy ? pol : ~pol) : pol;
    exp_oe = drv | busy;
    check(req, {30'b0, pad_oe, pad_o}, {30'b0, exp_oe, exp_o});
  endtask

  task automatic fire();
    @(negedge clk); trig = 1; tick_1us = 0;
    @(negedge clk); trig = 0;
  endtask

  task automatic count_ticks(logic pol, output int n);
    int k = 0;
    n = 0;
    while (asserted(pol) && k < 5000) begin
      tick_1us = (k % 3 == 2);
      @(negedge clk);
      if (tick_1us) n++;
      k++;
    end
    tick_1us = 0;
  endtask

  task automatic give_ticks(int t);
    for (int i = 0; i < t; i++) begin
      tick_1us = 1; @(negedge clk); tick_1us = 0; @(negedge clk);
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 readback", cfg_rdata, 32'h000000FF);
    pad_chk("R1 idle pad", 0, 0, 0);
    fire();
    pad_chk("R10 asserted od low", 1, 0, 0);
    count_ticks(0, n);
    check("R1 default length", n, 256);
    pad_chk("R10 idle od low", 0, 0, 0);

    foreach (VEC[i]) begin
      wr(VEC[i][63:32]);
      check($sformatf("R6 vector %0d", i), cfg_rdata, VEC[i][31:0]);
    end

    wr(32'h00000000);
    fire();
    count_ticks(0, n);
    check("R7 length 0", n, 1);
    wr(32'hA5000005);
    wr(32'hA8000005);
    pad_chk("R9 idle pp high", 0, 1, 1);
    fire();
    pad_chk("R9 asserted pp high", 1, 1, 1);
    count_ticks(1, n);
    check("R7 length 5", n, 6);
    wr(32'h5A000002);
    pad_chk("R9 idle pp low", 0, 0, 1);
    fire();
    pad_chk("R9 asserted pp low", 1, 0, 1);
    count_ticks(0, n);
    check("R7 length 2 pp", n, 3);
    wr(32'hA5000002);
    wr(32'h8A000002);
    pad_chk("R10 idle od high", 0, 1, 0);
    fire();
    pad_chk("R10 asserted od high", 1, 1, 0);
    count_ticks(1, n);
    check("R7 length 2 od", n, 3);

    wr(32'h00000004);
    fire();
    give_ticks(3);
    check("R8 still asserted", {31'b0, asserted(1)}, 32'd1);
    fire();
    count_ticks(1, n);
    check("R8 retrigger reload", n, 5);

    wr(32'h00000003);
    fire();
    wr(32'h00000009);
    count_ticks(1, n);
    check("R11 old length kept", n, 4);
    fire();
    count_ticks(1, n);
    check("R11 new length used", n, 10);

    @(negedge clk); trig = 1; tick_1us = 1;
    @(negedge clk); trig = 0; tick_1us = 0;
    count_ticks(1, n);
    check("R7 tick with trigger ignored", n, 10);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule